// File: doc/BRIEF.md
# Binary and Packed-Decimal Add/Subtract Unit

This unit adds with carry or subtracts with borrow on two operand words, at either the full 16-bit width or the low 8 bits. A decimal flag switches it from plain two's-complement arithmetic to packed BCD arithmetic. In BCD mode the correction to valid digits happens inside the same operation, so no separate adjust step is needed. The digit count follows the width: two digits at 8 bits and four digits at 16 bits. Along with the result it returns carry, zero, overflow and negative flags.

A request is presented on one clock edge with `in_valid` high. The result and the flags are registered and appear one cycle later with `out_valid`. They then hold until the next request. In 8-bit mode the upper byte of the result passes through from the first operand. Subtraction follows the convention where a carry-in of 1 means "no borrow pending" and a carry-out of 1 means "no borrow occurred".

Top module: `bcd_addsub_unit`

## Requirements
- R1: While reset is asserted, and until the first request after it, `out_valid`, `result` and all four flags are 0.
- R2: A request accepted on a clock edge (`in_valid`=1) produces its result and flags on that edge, with `out_valid`=1. When `in_valid`=0, `out_valid` is 0 on the following edge and `result` and the flags keep their values.
- R3: With `dec_mode`=0 and `op_sub`=0, the result at the active width (`wide`=1: 16 bits, `wide`=0: 8 bits) is `opa + opb + carry_in` modulo 2^width. `c_out` is the carry out of the top bit.
- R4: With `dec_mode`=0 and `op_sub`=1, the result is `opa - opb - (1 - carry_in)` modulo 2^width. `c_out` is 1 exactly when no borrow occurred.
- R5: With `dec_mode`=1 and `op_sub`=0, and valid BCD operands (nibble 0 is the least significant digit), the result is the packed-BCD sum of 2 (8-bit) or 4 (16-bit) digits plus `carry_in`, modulo 10^digits. `c_out` is 1 when the decimal sum reaches 10^digits.
- R6: With `dec_mode`=1 and `op_sub`=1, and valid BCD operands, the result is the packed-BCD value of `opa - opb - (1 - carry_in)` modulo 10^digits. `c_out` is 1 exactly when that difference is not negative.
- R7: With `wide`=0, `result[15:8]` equals `opa[15:8]` of the same request, in every mode.
- R8: `n_out` equals the most significant result bit at the active width (bit 15 or bit 7).
- R9: `v_out` is the signed two's-complement overflow of the binary add or subtract of the same operands at the active width. This holds in decimal mode too.
- R10: `z_out` is 1 exactly when the active-width result is 0. The exception is decimal addition, where `z_out` reflects the uncorrected binary sum; software must not treat it as the decimal zero indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op_sub | input | 1 | 1 = subtract with borrow, 0 = add with carry |
| wide | input | 1 | 1 = 16-bit width, 0 = 8-bit width |
| dec_mode | input | 1 | 1 = packed BCD, 0 = binary |
| carry_in | input | 1 | Carry in (subtract: 1 = no borrow pending) |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| out_valid | output | 1 | Result valid, one cycle after the request |
| result | output | 16 | Registered result |
| c_out | output | 1 | Carry, or inverted borrow |
| z_out | output | 1 | Zero flag |
| v_out | output | 1 | Signed overflow flag |
| n_out | output | 1 | Negative flag |

## Verification
The bench goes after the digit-wrap points: 99+01, 9999+0001, 00-01 and 1000-0001. A unit whose correction did not ripple across nibbles would return 0x9A or 0x0A00-style non-BCD values there, and a wrong borrow polarity would flip `c_out` on every subtraction. The signed-overflow edges 7F+01 and 80-01 are checked at 8-bit width, where a unit that took overflow from bit 15 would leave `v_out` clear. An 8-bit request with a non-zero upper operand byte catches a unit that lets the adder or the correction touch the upper result byte. A decimal 99+01 checks that zero follows the binary sum 0x9A and stays clear even though the corrected result is 0.

// File: rtl/bcd_au_pkg.sv
package bcd_au_pkg;

  localparam int NIB = 4;

  // One decimal digit of an add: returns {carry, digit}
  function automatic logic [4:0] dec_add_digit(input logic [3:0] x,
                                               input logic [3:0] y,
                                               input logic       ci);
    logic [5:0] t;
    t = {2'b00, x} + {2'b00, y} + {5'b0, ci};
    if (t > 6'd9) begin
      t = t + 6'd6;
      return {1'b1, t[3:0]};
    end
    return {1'b0, t[3:0]};
  endfunction

  // One decimal digit of a subtract: returns {borrow, digit}
  function automatic logic [4:0] dec_sub_digit(input logic [3:0] x,
                                               input logic [3:0] y,
                                               input logic       bi);
    logic [5:0] t;
    t = {2'b00, x} - {2'b00, y} - {5'b0, bi};
    if (t[5]) begin
      t = t - 6'd6;
      return {1'b1, t[3:0]};
    end
    return {1'b0, t[3:0]};
  endfunction

endpackage

// File: rtl/bau_digit_cell.sv
module bau_digit_cell
  import bcd_au_pkg::*;
(
  input  logic [NIB-1:0] x,
  input  logic [NIB-1:0] y,
  input  logic           sub,
  input  logic           ci,
  output logic [NIB-1:0] d,
  output logic           co
);
  logic [NIB:0] packed_out;

  always_comb begin
    packed_out = sub ? dec_sub_digit(x, y, ci) : dec_add_digit(x, y, ci);
    d  = packed_out[NIB-1:0];
    co = packed_out[NIB];
    if (x <= 4'd9 && y <= 4'd9) begin
      // R5
      digit_range_chk: assert (d <= 4'd9);
    end
  end
endmodule

// File: rtl/bau_bcd_chain.sv
module bau_bcd_chain #(
  parameter int DIGITS = 4
) (
  input  logic [DIGITS*4-1:0] a,
  input  logic [DIGITS*4-1:0] b,
  input  logic                sub,
  input  logic                cin,
  output logic [DIGITS*4-1:0] dec_res,
  output logic                c_half,
  output logic                c_full
);
  localparam int HALF = DIGITS / 2;

  // ripple: carry for add, borrow for subtract
  logic [DIGITS:0] rip;
  assign rip[0] = sub ? ~cin : cin;

  for (genvar k = 0; k < DIGITS; k++) begin : g_digit
    bau_digit_cell u_cell (
      .x  (a[4*k +: 4]),
      .y  (b[4*k +: 4]),
      .sub(sub),
      .ci (rip[k]),
      .d  (dec_res[4*k +: 4]),
      .co (rip[k+1])
    );
  end

  assign c_half = sub ? ~rip[HALF]   : rip[HALF];
  assign c_full = sub ? ~rip[DIGITS] : rip[DIGITS];
endmodule

// File: rtl/bau_bin_core.sv
module bau_bin_core #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         wide,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         c,
  output logic         v
);
  localparam int HW = W / 2;

  logic [W-1:0] b_eff;
  logic [W:0]   s_full;
  logic [HW:0]  s_half;
  logic         same_ops;

  always_comb begin
    b_eff  = sub ? ~b : b;
    s_full = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
    s_half = {1'b0, a[HW-1:0]} + {1'b0, b_eff[HW-1:0]} + {{HW{1'b0}}, cin};
    if (wide) begin
      res = s_full[W-1:0];
      c   = s_full[W];
      v   = (a[W-1] == b_eff[W-1]) && (s_full[W-1] != a[W-1]);
    end else begin
      res = {a[W-1:HW], s_half[HW-1:0]};
      c   = s_half[HW];
      v   = (a[HW-1] == b_eff[HW-1]) && (s_half[HW-1] != a[HW-1]);
    end
    same_ops = wide ? (a == b) : (a[HW-1:0] == b[HW-1:0]);
    if (sub && cin && same_ops) begin
      // R4
      self_sub_chk: assert (c && !v && (wide ? res == '0 : res[HW-1:0] == '0));
    end
  end
endmodule

// File: rtl/bcd_addsub_unit.sv
module bcd_addsub_unit #(
  parameter int DIGITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                op_sub,
  input  logic                wide,
  input  logic                dec_mode,
  input  logic                carry_in,
  input  logic [DIGITS*4-1:0] opa,
  input  logic [DIGITS*4-1:0] opb,
  output logic                out_valid,
  output logic [DIGITS*4-1:0] result,
  output logic                c_out,
  output logic                z_out,
  output logic                v_out,
  output logic                n_out
);
  localparam int W  = DIGITS * 4;
  localparam int HW = W / 2;

  logic [W-1:0] bin_res, dec_res, fin_res, zero_src;
  logic         bin_c, bin_v, dec_c_half, dec_c_full;
  logic         fin_c, fin_z, fin_n;
  logic         dec_add_quirk;

  bau_bin_core #(.W(W)) u_bin (
    .a(opa), .b(opb), .sub(op_sub), .wide(wide), .cin(carry_in),
    .res(bin_res), .c(bin_c), .v(bin_v)
  );

  bau_bcd_chain #(.DIGITS(DIGITS)) u_dec (
    .a(opa), .b(opb), .sub(op_sub), .cin(carry_in),
    .dec_res(dec_res), .c_half(dec_c_half), .c_full(dec_c_full)
  );

  assign dec_add_quirk = dec_mode && !op_sub;

  always_comb begin
    if (dec_mode) begin
      fin_res = wide ? dec_res : {opa[W-1:HW], dec_res[HW-1:0]};
      fin_c   = wide ? dec_c_full : dec_c_half;
    end else begin
      fin_res = bin_res;
      fin_c   = bin_c;
    end
    zero_src = dec_add_quirk ? bin_res : fin_res;
    fin_z    = wide ? (zero_src == '0) : (zero_src[HW-1:0] == '0);
    fin_n    = wide ? fin_res[W-1] : fin_res[HW-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      c_out     <= 1'b0;
      z_out     <= 1'b0;
      v_out     <= 1'b0;
      n_out     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= fin_res;
        c_out  <= fin_c;
        z_out  <= fin_z;
        v_out  <= bin_v;
        n_out  <= fin_n;
      end
    end
  end

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(c_out)));

  // R7
  upper_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wide) |=> (result[W-1:HW] == $past(opa[W-1:HW])));

  // R8
  negative_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (n_out == ($past(wide) ? result[W-1] : result[HW-1])));

  // R10
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dec_add_quirk) |=>
      (z_out == ($past(wide) ? (result == '0) : (result[HW-1:0] == '0))));
endmodule

// File: tb/bcd_addsub_unit_bench.sv
module bcd_addsub_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, op_sub = 1'b0, wide = 1'b0, dec_mode = 1'b0, carry_in = 1'b0;
  logic [15:0] opa = '0, opb = '0;
  logic        out_valid;
  logic [15:0] result;
  logic        c_out, z_out, v_out, n_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bcd_addsub_unit u_bcd_addsub_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub), .wide(wide),
    .dec_mode(dec_mode), .carry_in(carry_in), .opa(opa), .opb(opb),
    .out_valid(out_valid), .result(result), .c_out(c_out), .z_out(z_out),
    .v_out(v_out), .n_out(n_out)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int bcd_to_int(input int v, input int nd);
    int acc = 0;
    for (int k = nd - 1; k >= 0; k--) acc = acc * 10 + ((v >> (4 * k)) & 15);
    return acc;
  endfunction

  function automatic int int_to_bcd(input int v, input int nd);
    int acc = 0;
    for (int k = 0; k < nd; k++) begin
      acc = acc | ((v % 10) << (4 * k));
      v = v / 10;
    end
    return acc;
  endfunction

  // Apply one request and compare with a model built from R3..R10
  task automatic run(input string req, input bit sub, input bit wd, input bit dec,
                     input bit ci, input int a, input int b);
    int mask, nbits, nd, am, bm, sa, sb, sv, s, r, braw, full;
    bit c, z, v, n;
    nbits = wd ? 16 : 8;
    mask  = (1 << nbits) - 1;
    nd    = nbits / 4;
    am = a & mask;
    bm = b & mask;
    // binary sum for V and the decimal-add zero rule
    braw = sub ? (am - bm - (1 - ci)) : (am + bm + ci);
    sa = (am >= (1 << (nbits - 1))) ? am - (1 << nbits) : am;
    sb = (bm >= (1 << (nbits - 1))) ? bm - (1 << nbits) : bm;
    sv = sub ? (sa - sb - (1 - ci)) : (sa + sb + ci);
    v  = (sv > (1 << (nbits - 1)) - 1) || (sv < -(1 << (nbits - 1)));
    if (!dec) begin
      r = braw & mask;
      c = sub ? (braw >= 0) : (braw > mask);
    end else begin
      int p10 = 1;
      for (int k = 0; k < nd; k++) p10 = p10 * 10;
      s = sub ? (bcd_to_int(am, nd) - bcd_to_int(bm, nd) - (1 - ci))
              : (bcd_to_int(am, nd) + bcd_to_int(bm, nd) + ci);
      c = sub ? (s >= 0) : (s >= p10);
      r = int_to_bcd((s + p10) % p10, nd);
    end
    z = (dec && !sub) ? ((braw & mask) == 0) : (r == 0);
    n = (r >> (nbits - 1)) & 1;
    full = wd ? r : ((a & 16'hFF00) | r);

    @(negedge clk);
    in_valid = 1'b1; op_sub = sub; wide = wd; dec_mode = dec; carry_in = ci;
    opa = a[15:0]; opb = b[15:0];
    @(negedge clk);
    in_valid = 1'b0;
    check("R2", {req, " valid"}, int'(out_valid), 1);
    check(req, "result", int'(result), full);
    check(req, "carry", int'(c_out), int'(c));
    check("R9", {req, " overflow"}, int'(v_out), int'(v));
    check("R8", {req, " negative"}, int'(n_out), int'(n));
    check("R10", {req, " zero"}, int'(z_out), int'(z));
  endtask

  task automatic t_reset();
    check("R1", "valid in reset", int'(out_valid), 0);
    check("R1", "result in reset", int'(result), 0);
    check("R1", "flags in reset", int'({c_out, z_out, v_out, n_out}), 0);
  endtask

  task automatic t_bin_add();
    run("R3", 0, 0, 0, 0, 16'h007F, 16'h0001);
    run("R3", 0, 0, 0, 0, 16'h00FF, 16'h0001);
    run("R3", 0, 1, 0, 1, 16'hFFFF, 16'h0000);
    run("R3", 0, 1, 0, 0, 16'h7FFF, 16'h0001);
    run("R3", 0, 1, 0, 1, 16'h1234, 16'h4321);
  endtask

  task automatic t_bin_sub();
    run("R4", 1, 0, 0, 1, 16'h0000, 16'h0001);
    run("R4", 1, 0, 0, 1, 16'h0080, 16'h0001);
    run("R4", 1, 1, 0, 1, 16'h1234, 16'h1234);
    run("R4", 1, 1, 0, 0, 16'h8000, 16'h0000);
  endtask

  task automatic t_dec_add();
    run("R5", 0, 0, 1, 0, 16'h0045, 16'h0038);
    run("R5", 0, 1, 1, 0, 16'h9999, 16'h0001);
    run("R5", 0, 1, 1, 1, 16'h1234, 16'h8766);
    run("R5", 0, 1, 1, 0, 16'h0509, 16'h0491);
  endtask

  task automatic t_dec_sub();
    run("R6", 1, 0, 1, 1, 16'h0000, 16'h0001);
    run("R6", 1, 0, 1, 1, 16'h0050, 16'h0025);
    run("R6", 1, 0, 1, 1, 16'h0050, 16'h0050);
    run("R6", 1, 1, 1, 1, 16'h1000, 16'h0001);
    run("R6", 1, 1, 1, 0, 16'h1000, 16'h0001);
  endtask

  task automatic t_upper_pass();
    run("R7", 0, 0, 0, 1, 16'hAB12, 16'hCD34);
    run("R7", 1, 0, 1, 1, 16'h5E20, 16'hFF11);
  endtask

  task automatic t_zero_quirk();
    // R10: decimal 99+01 gives 00 with carry, zero follows binary 0x9A
    run("R10", 0, 0, 1, 0, 16'h0099, 16'h0001);
    check("R10", "quirk result", int'(result), 16'h0000);
    check("R10", "quirk zero", int'(z_out), 0);
  endtask

  task automatic t_hold();
    logic [15:0] keep;
    keep = result;
    @(negedge clk);
    opa = 16'h1111; opb = 16'h2222; dec_mode = 1'b0; wide = 1'b1;
    @(negedge clk);
    check("R2", "no valid when idle", int'(out_valid), 0);
    check("R2", "result held when idle", int'(result), int'(keep));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bin_add();
    t_bin_sub();
    t_dec_add();
    t_dec_sub();
    t_upper_pass();
    t_zero_quirk();
    t_hold();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule